// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory with a fixed two-cycle data lag. A command (address, read/write choice, byte write mask, chip selects) is sampled on one clock edge. The data for that command moves in the bus cycle that follows the next enabled edge. For a read, the word is driven on `rdata` during that cycle. For a write, the word is taken from `wdata` at the edge that closes that cycle. Reads and writes share the same lag, so a host can alternate them on every cycle with no idle cycles in between.

A clock enable freezes the whole block. Three chip selects, two active low and one active high, can turn an edge into a deselect cycle that starts no access while earlier accesses still finish. Writes merge only the enabled 9-bit bytes into the stored word. A read that follows a write to the same address sees the new bytes at once, through a forwarding path from the write stage. An asynchronous output enable gates the bus. The burst address sequence, where one is needed, comes from a separate sequencer that presents one address per command.

Top module: `zt_sram`

## Requirements
- R1: A read command sampled at enabled edge n is driven with `bus_drive`=1 and the stored word on `rdata` from enabled edge n+1 until the following enabled edge, provided `oe_n` is low.
- R2: For a write command sampled at enabled edge n, `wdata` is sampled at enabled edge n+2. Byte i (bits 9i+8..9i) of the stored word is replaced only when `byte_wr_n[i]` was 0 at edge n.
- R3: Reads and writes may be issued on consecutive enabled edges with no idle cycle. A read issued one or two enabled edges after a write to the same address returns the newly merged word.
- R4: The chip is selected only when `sel0_n`=0, `sel1_n`=0 and `sel2`=1. An enabled edge without selection starts no access and writes nothing, but accesses already issued still complete.
- R5: In the data cycle of a write or of a deselect cycle, `bus_drive` is 0 and `rdata` is all zeros (the bus is released).
- R6: When `clk_en_n` is 1 at an edge, that edge has no effect: command inputs and `wdata` are ignored, pending accesses do not advance, and `rdata`/`bus_drive` keep their values.
- R7: `oe_n`=1 forces `bus_drive` to 0 and `rdata` to zeros at once, without a clock edge. Returning `oe_n` to 0 restores the pending read data immediately.
- R8: `byte_wr_n` is ignored on read commands: a read never alters the stored word, whatever the mask.
- R9: While `rst_n` is low, `bus_drive` is 0 and `rdata` is zero, and every access in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; 1 stalls the block |
| sel0_n | input | 1 | Active-low chip select |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| rw | input | 1 | Command type: 1 read, 0 write |
| addr | input | ADDR_W | Word address of the command |
| byte_wr_n | input | BYTES | Active-low write enable per 9-bit byte |
| wdata | input | BYTES*BYTE_W | Write data, sampled two enabled edges after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | BYTES*BYTE_W | Read data, zero when the bus is released |
| bus_drive | output | 1 | 1 while the block drives the data bus |

## Verification
The main function is tried with isolated reads and writes separated by deselect cycles, which pin the two-cycle lag apart from any neighbouring access. Tightly alternating write-read pairs to the same address at distances of one and two edges separate the forwarding path from the array read. Partial byte masks on writes and random masks on reads show whether merging follows the mask only where it should. Long random mixes with stalls, deselects and output-enable toggles show whether stalls freeze the lag exactly and whether deselects leave in-flight accesses intact.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // Operation carried down the command pipeline
  typedef enum logic [1:0] {
    ZT_IDLE  = 2'd0,
    ZT_READ  = 2'd1,
    ZT_WRITE = 2'd2
  } zt_op_e;
endpackage

// File: rtl/zt_rst_sync.sv
module zt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
  import zt_sram_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic             sel0_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             rw,
  input  logic [BYTES-1:0] byte_wr_n,
  output zt_op_e           op,
  output logic [BYTES-1:0] wmask
);
  logic chip_on;

  always_comb begin
    chip_on = !sel0_n && !sel1_n && sel2;
    if (!chip_on)  op = ZT_IDLE;
    else if (rw)   op = ZT_READ;
    else           op = ZT_WRITE;
    // mask only matters for a selected write; reads carry none
    wmask = (chip_on && !rw) ? ~byte_wr_n : '0;
  end
endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  zt_op_e            in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BYTES-1:0]  in_mask,
  output zt_op_e            rd_op,
  output logic [ADDR_W-1:0] rd_addr,
  output zt_op_e            wr_op,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTES-1:0]  wr_mask
);
  localparam int STAGES = 2;

  zt_op_e            op_q   [STAGES];
  zt_op_e            op_d   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [ADDR_W-1:0] addr_d [STAGES];
  logic [BYTES-1:0]  mask_q [STAGES];
  logic [BYTES-1:0]  mask_d [STAGES];

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      op_d[i]   = op_q[i];
      addr_d[i] = addr_q[i];
      mask_d[i] = mask_q[i];
    end
    if (adv) begin
      op_d[0]   = in_op;
      addr_d[0] = in_addr;
      mask_d[0] = in_mask;
      for (int i = 1; i < STAGES; i++) begin
        op_d[i]   = op_q[i-1];
        addr_d[i] = addr_q[i-1];
        mask_d[i] = mask_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        op_q[i]   <= ZT_IDLE;
        addr_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        op_q[i]   <= op_d[i];
        addr_q[i] <= addr_d[i];
        mask_q[i] <= mask_d[i];
      end
    end
  end

  assign rd_op   = op_q[0];
  assign rd_addr = addr_q[0];
  assign wr_op   = op_q[STAGES-1];
  assign wr_addr = addr_q[STAGES-1];
  assign wr_mask = mask_q[STAGES-1];
endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    commit_en,
  input  logic [ADDR_W-1:0]       commit_addr,
  input  logic [BYTES-1:0]        commit_mask,
  input  logic [BYTES*BYTE_W-1:0] commit_data,
  input  logic [ADDR_W-1:0]       look_addr,
  output logic [BYTES*BYTE_W-1:0] look_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged;

  assign old_word = cells[commit_addr];

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = commit_mask[b] ? commit_data[b*BYTE_W +: BYTE_W]
                                                       : old_word[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (commit_en) cells[commit_addr] <= merged;
  end

  assign look_data = cells[look_addr];
endmodule

// File: rtl/zt_read_port.sv
module zt_read_port #(
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    rd_req,
  input  logic [BYTES*BYTE_W-1:0] array_word,
  input  logic                    pend_hit,
  input  logic [BYTES-1:0]        pend_mask,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    bus_drive
);
  localparam int DATA_W = BYTES * BYTE_W;

  logic [DATA_W-1:0] fwd_word;
  logic [DATA_W-1:0] out_q, out_d;
  logic              drive_q, drive_d;

  // bytes of a write committing this edge override the array copy
  for (genvar b = 0; b < BYTES; b++) begin : g_fwd
    assign fwd_word[b*BYTE_W +: BYTE_W] = (pend_hit && pend_mask[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                                      : array_word[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    out_d   = out_q;
    drive_d = drive_q;
    if (adv) begin
      drive_d = rd_req;
      out_d   = rd_req ? fwd_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      drive_q <= drive_d;
    end
  end

  assign bus_drive = drive_q & ~oe_n;
  assign rdata     = bus_drive ? out_q : '0;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_wr_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_drive
);
  logic              rst_n_int;
  logic              adv;
  zt_op_e            dec_op;
  logic [BYTES-1:0]  dec_mask;
  zt_op_e            rd_op, wr_op;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTES-1:0]  wr_mask;
  logic [DATA_W-1:0] array_word;
  logic              commit_en;
  logic              pend_hit;

  assign adv       = !clk_en_n;
  assign commit_en = adv && (wr_op == ZT_WRITE);
  assign pend_hit  = (wr_op == ZT_WRITE) && (wr_addr == rd_addr);

  zt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  zt_cmd_decode #(.BYTES(BYTES)) u_decode (
    .sel0_n    (sel0_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .rw        (rw),
    .byte_wr_n (byte_wr_n),
    .op        (dec_op),
    .wmask     (dec_mask)
  );

  zt_cmd_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .adv     (adv),
    .in_op   (dec_op),
    .in_addr (addr),
    .in_mask (dec_mask),
    .rd_op   (rd_op),
    .rd_addr (rd_addr),
    .wr_op   (wr_op),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask)
  );

  zt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk         (clk),
    .commit_en   (commit_en),
    .commit_addr (wr_addr),
    .commit_mask (wr_mask),
    .commit_data (wdata),
    .look_addr   (rd_addr),
    .look_data   (array_word)
  );

  zt_read_port #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_read_port (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .adv        (adv),
    .rd_req     (rd_op == ZT_READ),
    .array_word (array_word),
    .pend_hit   (pend_hit),
    .pend_mask  (wr_mask),
    .wdata      (wdata),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .bus_drive  (bus_drive)
  );
endmodule

// File: rtl/zt_sram_checker.sv
module zt_sram_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sel0_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              rw,
  input logic              oe_n,
  input logic [DATA_W-1:0] rdata,
  input logic              bus_drive
);
  // edges since reset release; commands count once the internal sync is done
  logic [1:0] up_q;
  logic       live;
  logic       chip_on;
  logic       cmd_rd, cmd_wr, cmd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_q <= '0;
    else if (up_q != 2'd3)  up_q <= up_q + 2'd1;
  end

  assign live    = (up_q >= 2'd2);
  assign chip_on = !sel0_n && !sel1_n && sel2;
  assign cmd_rd  = live && !clk_en_n && chip_on && rw;
  assign cmd_wr  = live && !clk_en_n && chip_on && !rw;
  assign cmd_off = live && !clk_en_n && !chip_on;

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd ##1 !clk_en_n) |=> (bus_drive == !oe_n));

  assert_deselect_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_off ##1 !clk_en_n) |=> !bus_drive);

  assert_write_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr ##1 !clk_en_n) |=> (!bus_drive && rdata == '0));

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_en_n) && $stable(oe_n)) |-> ($stable(bus_drive) && $stable(rdata)));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> !bus_drive);
endmodule

bind zt_sram zt_sram_checker #(.DATA_W(DATA_W)) u_zt_sram_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .sel0_n    (sel0_n),
  .sel1_n    (sel1_n),
  .sel2      (sel2),
  .rw        (rw),
  .oe_n      (oe_n),
  .rdata     (rdata),
  .bus_drive (bus_drive)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, sel0_n, sel1_n, sel2, rw, oe_n;
  logic [AW-1:0] addr;
  logic [NB-1:0] byte_wr_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          bus_drive;

  always #2.5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .sel2(sel2), .rw(rw), .addr(addr), .byte_wr_n(byte_wr_n), .wdata(wdata),
    .oe_n(oe_n), .rdata(rdata), .bus_drive(bus_drive));

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state: 0 idle, 1 read, 2 write
  logic [DW-1:0] ref_mem [DEPTH];
  int            p1_op, p2_op;
  logic [AW-1:0] p1_addr, p2_addr;
  logic [NB-1:0] p1_mask, p2_mask;
  logic          exp_drv;
  logic [DW-1:0] exp_d;
  logic [DW-1:0] wq0, wq1;

  function automatic logic [DW-1:0] fill_val(input int a);
    logic [31:0] v;
    v = 32'h2A5A5 ^ (a * 32'h1357);
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] m);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++) if (m[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_out(input string tag);
    logic vis;
    vis = exp_drv && !oe_n;
    chk(tag, {31'd0, bus_drive}, {31'd0, vis});
    chk(tag, {{(32-DW){1'b0}}, rdata}, {{(32-DW){1'b0}}, (vis ? exp_d : '0)});
  endtask

  task automatic model_reset();
    p1_op = 0; p2_op = 0; p1_addr = '0; p2_addr = '0; p1_mask = '0; p2_mask = '0;
    exp_drv = 1'b0; exp_d = '0;
  endtask

  // one clock edge with explicit inputs; the model advances only on enabled edges
  task automatic cyc(input logic ce_n, input logic s0n, input logic s1n, input logic s2,
                     input logic rwv, input logic [AW-1:0] a, input logic [NB-1:0] bwn,
                     input logic [DW-1:0] wd, input logic oe, input string tag);
    logic on;
    @(negedge clk);
    clk_en_n = ce_n; sel0_n = s0n; sel1_n = s1n; sel2 = s2; rw = rwv;
    addr = a; byte_wr_n = bwn; wdata = wd; oe_n = oe;
    @(posedge clk);
    if (!ce_n) begin
      if (p2_op == 2) ref_mem[p2_addr] = merge(ref_mem[p2_addr], wd, p2_mask);
      if (p1_op == 1) begin exp_drv = 1'b1; exp_d = ref_mem[p1_addr]; end
      else            begin exp_drv = 1'b0; exp_d = '0; end
      p2_op = p1_op; p2_addr = p1_addr; p2_mask = p1_mask;
      on = !s0n && !s1n && s2;
      p1_op   = !on ? 0 : (rwv ? 1 : 2);
      p1_addr = a;
      p1_mask = (on && !rwv) ? ~bwn : '0;
    end
    #1;
    check_out(tag);
  endtask

  // enabled edge; write data follows its command by two enabled edges
  task automatic go(input logic s0n, input logic s1n, input logic s2, input logic rwv,
                    input logic [AW-1:0] a, input logic [NB-1:0] bwn, input logic [DW-1:0] d,
                    input logic oe, input string tag);
    cyc(1'b0, s0n, s1n, s2, rwv, a, bwn, wq1, oe, tag);
    wq1 = wq0;
    wq0 = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [NB-1:0] bwn, input string tag);
    go(1'b0, 1'b0, 1'b1, 1'b1, a, bwn, '0, 1'b0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bwn, input logic [DW-1:0] d,
                    input string tag);
    go(1'b0, 1'b0, 1'b1, 1'b0, a, bwn, d, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    go(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, '0, {DW{1'b1}}, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    model_reset();
    wq0 = '0; wq1 = '0;
    rst_n = 1'b0; clk_en_n = 1'b0; sel0_n = 1'b1; sel1_n = 1'b0; sel2 = 1'b1;
    rw = 1'b0; addr = '0; byte_wr_n = '0; wdata = '0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset drive", {31'd0, bus_drive}, 32'd0);
    chk("R9 reset data", {{(32-DW){1'b0}}, rdata}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle("R9");

    // fill every word
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 2'b00, fill_val(a), "R2");
    repeat (2) idle("R5");

    // isolated read: data in the cycle after the next edge
    rd(4'd3, 2'b00, "R1");
    idle("R1");
    idle("R1");

    // partial write, byte 0 only (byte_wr_n = 2'b10)
    wr(4'd2, 2'b10, 18'h3_1234, "R2");
    idle("R5");
    idle("R2");
    rd(4'd2, 2'b00, "R2");
    idle("R2");
    idle("R2");

    // write/read alternation on one address
    wr(4'd5, 2'b00, 18'h2_AAAA, "R3");
    rd(4'd5, 2'b00, "R3");
    rd(4'd5, 2'b00, "R3");
    wr(4'd5, 2'b01, 18'h1_5555, "R3");
    idle("R3");
    rd(4'd5, 2'b00, "R3");
    wr(4'd6, 2'b00, 18'h0_0F0F, "R3");
    rd(4'd6, 2'b00, "R3");
    wr(4'd7, 2'b00, 18'h3_F00F, "R3");
    rd(4'd7, 2'b00, "R3");
    idle("R3");
    idle("R3");

    // mask on reads has no effect
    rd(4'd9, 2'b00, "R8");
    rd(4'd9, 2'b01, "R8");
    rd(4'd9, 2'b10, "R8");
    rd(4'd9, 2'b00, "R8");
    idle("R8");
    idle("R8");

    // each select alone blocks a write; pending read still completes
    rd(4'd10, 2'b00, "R4");
    go(1'b1, 1'b0, 1'b1, 1'b0, 4'd10, 2'b00, 18'h0_0001, 1'b0, "R4");
    go(1'b0, 1'b1, 1'b1, 1'b0, 4'd10, 2'b00, 18'h0_0002, 1'b0, "R4");
    go(1'b0, 1'b0, 1'b0, 1'b0, 4'd10, 2'b00, 18'h0_0003, 1'b0, "R4");
    rd(4'd10, 2'b00, "R4");
    idle("R4");
    idle("R4");

    // stalls: read data held, write data edge deferred
    rd(4'd11, 2'b00, "R6");
    idle("R6");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11, 2'b00, 18'h3_FFFF, 1'b0, "R6");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 2'b00, 18'h3_FFFF, 1'b0, "R6");
    wr(4'd12, 2'b00, 18'h1_2345, "R6");
    idle("R6");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd12, 2'b00, 18'h0_0BAD, 1'b0, "R6");
    idle("R6");
    rd(4'd12, 2'b00, "R6");
    idle("R6");
    idle("R6");

    // asynchronous output enable
    rd(4'd8, 2'b00, "R7");
    idle("R7");
    oe_n = 1'b1; #0.5;
    chk("R7 oe high drive", {31'd0, bus_drive}, 32'd0);
    chk("R7 oe high data", {{(32-DW){1'b0}}, rdata}, 32'd0);
    oe_n = 1'b0; #0.5;
    chk("R7 oe low drive", {31'd0, bus_drive}, 32'd1);
    chk("R7 oe low data", {{(32-DW){1'b0}}, rdata}, {{(32-DW){1'b0}}, ref_mem[8]});
    idle("R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic ce_n, s0n, s1n, s2, rwv, oe;
      logic [AW-1:0] a;
      logic [NB-1:0] bwn;
      logic [DW-1:0] d;
      r = $urandom; ce_n = (r[3:0] < 4'd2);
      r = $urandom; s0n = (r[4:0] == 5'd0); s1n = (r[9:5] == 5'd0); s2 = (r[14:10] != 5'd0);
      rwv = r[15]; oe = (r[19:16] == 4'd0); a = r[23:20]; bwn = r[25:24];
      r = $urandom; d = r[DW-1:0];
      if (ce_n) cyc(1'b1, s0n, s1n, s2, rwv, a, bwn, d, oe, "R1 random stall");
      else      go(s0n, s1n, s2, rwv, a, bwn, d, oe, "R1 random");
    end

    // reset in the middle of a read
    rd(4'd3, 2'b00, "R9");
    #1.5;
    rst_n = 1'b0; #0.5;
    chk("R9 async reset drive", {31'd0, bus_drive}, 32'd0);
    @(posedge clk); #1;
    chk("R9 reset drops read", {31'd0, bus_drive}, 32'd0);
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle("R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule